// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Single-Bit LRU

This block is a small read-only data cache that sits between a load unit and a slower next-level memory. It stores eight 32-bit words, each one word long, organised as four sets of two ways. A load presents a byte address with a one-cycle strobe. The cache looks the address up one cycle later and answers with a one-cycle response pulse that carries the data word and a flag that says whether the word was already resident.

On a miss, the cache issues a word-aligned request on its memory port. It holds that request until the memory signals ready together with the data, which can take any number of cycles. The returned word is written into one way of the indexed set and forwarded to the requester. A way that holds no valid line is always filled before a valid line is evicted. Once both ways are valid, a single bit per set names the way that was used less recently, and that way is replaced. Two free-running counters report how many accepted loads hit and how many missed, so miss rates can be measured directly.

Top module: `lru2_cache`

## Requirements
- R1: The byte address splits into a byte offset in bits [1:0], a set index in bits [3:2] and a 28-bit tag in bits [31:4]. Two loads that differ only in the offset refer to the same cached word.
- R2: A load hits when one way of its set is valid and holds the load's tag. The response then has `resp_hit`=1 and the data of that way. At most one way of a set hits.
- R3: On a miss, `mem_req` goes high with `mem_addr` equal to the load address with bits [1:0] cleared. It stays high with a stable address until `mem_ready` is seen. The word on `mem_data` in the `mem_ready` cycle is stored, and it is returned with `resp_hit`=0 in the very next cycle.
- R4: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. A hit raises `resp_valid` at the next rising edge. `resp_valid` lasts exactly one cycle per accepted load.
- R5: On a miss, an invalid way is filled before any valid way is evicted, and way 0 is taken before way 1.
- R6: Each set keeps one bit naming its less recently used way. The bit is updated on every hit and every fill. When both ways are valid, the way it names is replaced. After loads to 0x04 and then 0x24, a load to 0x54 replaces 0x04 and keeps 0x24.
- R7: Five rounds of alternating loads to 0x04 and 0x24, starting from reset, give exactly 2 misses and 8 hits.
- R8: `req_ready` is 0 from acceptance until the response. A `req_valid` in that interval is ignored: it produces no response and no count, and it leaves no line in the cache.
- R9: A synchronous active-low reset clears all valid bits, use bits and both counters. After reset, `req_ready`=1, `resp_valid`=0 and `mem_req`=0.
- R10: `hit_count` increases by one for each accepted load that hits, and `miss_count` increases by one for each accepted load that misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Load strobe |
| req_addr | input | 32 | Load byte address |
| req_ready | output | 1 | Cache can accept a load |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response was served from the cache |
| resp_data | output | 32 | Loaded word |
| mem_req | output | 1 | Next-level read request, held until ready |
| mem_addr | output | 32 | Word-aligned next-level address |
| mem_ready | input | 1 | Next-level data valid, one cycle |
| mem_data | input | 32 | Next-level data word |
| hit_count | output | 16 | Accepted loads that hit |
| miss_count | output | 16 | Accepted loads that missed |

## Verification
The cache can deliver the response to one load in the same cycle that it accepts the next load, because `req_ready` comes back in the cycle of the response pulse. The bench issues every load at the first sampling point where `req_ready` is high, so that overlap is exercised on every transaction, both after hits and after fills. Each response is compared with a bench model of the tags, valid bits and use bits. That comparison shows whether the new lookup saw the array contents written by the fill that finished one edge earlier. The bench also holds `req_valid` high with an aliasing address while a load is in progress. It then checks that the alias later misses and that the counters did not move.

// File: rtl/cache_pkg.sv
// Shared types for the two-way read cache.
package cache_pkg;
    // Controller phases: waiting, tag compare, waiting for next level.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/cache_way_store.sv
// One way of the cache: a valid bit, a tag and a data word per set.
// Assumes the read set stays stable for the whole compare cycle. A write
// takes effect at the clock edge and is visible to the next read.
module cache_way_store #(
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    parameter int SET_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set] <= 1'b1;
        end
    end

    // Tag and data storage: written on a fill, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            data_q[wr_set] <= wr_data;
        end
    end

    // Read port: compare the stored tag of the addressed set.
    always_comb begin
        rd_valid = valid_q[rd_set];
        rd_hit   = valid_q[rd_set] && (tag_q[rd_set] == rd_tag);
        rd_data  = data_q[rd_set];
    end
endmodule

// File: rtl/cache_lru_sel.sv
// Per-set use bit and victim choice for a two-way cache.
// The use bit names the less recently used way. The victim is an invalid
// way if one exists (way 0 first), otherwise the way named by the use bit.
module cache_lru_sel #(
    parameter int SET_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic [1:0]       way_valid,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic             fill_way,
    output logic             victim_way
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] use_q;

    // Use bit update: the touched way becomes most recent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_q <= '0;
        end else if (touch_en) begin
            use_q[set_idx] <= ~touch_way;
        end
    end

    // Victim choice: prefer an empty way, else the older one.
    always_comb begin
        if (!way_valid[0]) begin
            victim_way = 1'b0;
        end else if (!way_valid[1]) begin
            victim_way = 1'b1;
        end else begin
            victim_way = use_q[set_idx];
        end
    end

    // R5: a fill never overwrites a valid line while the set has a free way.
    p_no_evict_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(&way_valid)) |-> !way_valid[fill_way]);

    // R6: after a touch of a set, that set's use bit points away from the touched way.
    p_use_follows_touch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (use_q[$past(set_idx)] != $past(touch_way)));
endmodule

// File: rtl/cache_ctrl.sv
// Request sequencer for the read cache.
// It accepts one load while idle and compares tags in the next cycle. On a
// miss it holds a next-level request until ready, and it produces a one-cycle
// response. It also counts hits and misses.
// Assumes mem_ready is only asserted while mem_req is high.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    output logic [ADDR_W-OFF_W-1:0] word_addr,
    input  logic                hit_any,
    input  logic                hit_way,
    input  logic [DATA_W-1:0]   hit_data,
    input  logic                victim_way,
    output logic                fill_en,
    output logic                fill_way,
    output logic                touch_en,
    output logic                touch_way,
    output logic                resp_valid,
    output logic                resp_hit,
    output logic [DATA_W-1:0]   resp_data,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ready,
    input  logic [DATA_W-1:0]   mem_data,
    output logic [CNT_W-1:0]    hit_count,
    output logic [CNT_W-1:0]    miss_count
);
    ctrl_state_t state_q;

    // Sequencer, response register and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            word_addr  <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        word_addr <= req_addr[ADDR_W-1:OFF_W];
                        state_q   <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (hit_any) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_data  <= hit_data;
                        hit_count  <= hit_count + 1'b1;
                        state_q    <= ST_IDLE;
                    end else begin
                        miss_count <= miss_count + 1'b1;
                        state_q    <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_data  <= mem_data;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake and array control derived from the phase.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_FILL);
        mem_addr  = {word_addr, {OFF_W{1'b0}}};
        fill_en   = (state_q == ST_FILL) && mem_ready;
        fill_way  = victim_way;
        touch_en  = ((state_q == ST_LOOK) && hit_any) || fill_en;
        touch_way = fill_en ? victim_way : hit_way;
    end

    // R8: no load is accepted while the next level is being waited on.
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R3: a pending next-level request holds with a stable address until ready.
    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R3: the fill word is returned as a miss in the following cycle.
    p_fill_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (resp_valid && !resp_hit && resp_data == $past(mem_data)));

    // R4: the response is a single-cycle pulse.
    p_resp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R10: a hit response comes with exactly one hit count.
    p_hit_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (hit_count == $past(hit_count) + 1'b1));
endmodule

// File: rtl/lru2_cache.sv
// Two-way set-associative read cache with one-word lines and single-bit LRU.
// Two way stores are compared in parallel, a use-bit unit picks the victim,
// and a sequencer handles the load and next-level handshakes.
// Assumes the next level answers each request exactly once.
module lru2_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    parameter int SET_W  = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int WORD_W = ADDR_W - OFF_W;
    localparam int TAG_W  = WORD_W - SET_W;
    localparam int WAYS   = 2;

    logic [WORD_W-1:0] word_addr;
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag_val;
    logic [WAYS-1:0]   way_hit;
    logic [WAYS-1:0]   way_valid;
    logic [DATA_W-1:0] way_data [WAYS];
    logic              hit_any;
    logic              hit_way;
    logic [DATA_W-1:0] hit_data;
    logic              victim_way;
    logic              fill_en;
    logic              fill_way;
    logic              touch_en;
    logic              touch_way;

    // Index and tag of the load under lookup.
    always_comb begin
        set_idx = word_addr[SET_W-1:0];
        tag_val = word_addr[WORD_W-1:SET_W];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache_way_store #(
            .TAG_W (TAG_W),
            .DATA_W(DATA_W),
            .SET_W (SET_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_set  (set_idx),
            .rd_tag  (tag_val),
            .rd_hit  (way_hit[w]),
            .rd_valid(way_valid[w]),
            .rd_data (way_data[w]),
            .wr_en   (fill_en && (fill_way == w[0])),
            .wr_set  (set_idx),
            .wr_tag  (tag_val),
            .wr_data (mem_data)
        );
    end

    // Combine the way compares into one hit and one data word.
    always_comb begin
        hit_any  = |way_hit;
        hit_way  = way_hit[1];
        hit_data = way_hit[1] ? way_data[1] : way_data[0];
    end

    cache_lru_sel #(
        .SET_W(SET_W)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (set_idx),
        .way_valid (way_valid),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .fill_en   (fill_en),
        .fill_way  (fill_way),
        .victim_way(victim_way)
    );

    cache_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .OFF_W (OFF_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .word_addr (word_addr),
        .hit_any   (hit_any),
        .hit_way   (hit_way),
        .hit_data  (hit_data),
        .victim_way(victim_way),
        .fill_en   (fill_en),
        .fill_way  (fill_way),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .resp_valid(resp_valid),
        .resp_hit  (resp_hit),
        .resp_data (resp_data),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ready (mem_ready),
        .mem_data  (mem_data),
        .hit_count (hit_count),
        .miss_count(miss_count)
    );

    // R2: the two way stores never both claim the same lookup.
    p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));
endmodule

// File: tb/lru2_cache_test.sv
`timescale 1ns/1ps
module lru2_cache_test;
    localparam int MEM_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_hit;
    logic [31:0] resp_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_data = '0;
    logic [15:0] hit_count;
    logic [15:0] miss_count;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Bench model of the cache contents.
    bit          mv [4][2];
    logic [27:0] mt [4][2];
    bit          mu [4];
    int          exp_hits = 0;
    int          exp_miss = 0;
    bit          last_hit;

    always #4 clk = ~clk;

    lru2_cache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_data(mem_data), .hit_count(hit_count),
        .miss_count(miss_count)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E3779B1) ^ 32'hC0FFEE11;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 4; s++) begin
            mv[s][0] = 0; mv[s][1] = 0; mu[s] = 0;
        end
        exp_hits = 0; exp_miss = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        chk("R9 ready", {31'd0, req_ready}, 32'd1);
        chk("R9 resp_valid", {31'd0, resp_valid}, 32'd0);
        chk("R9 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R9 hit_count", {16'd0, hit_count}, 32'd0);
        chk("R9 miss_count", {16'd0, miss_count}, 32'd0);
    endtask

    // Next-level memory with a fixed latency and a one-cycle ready.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                repeat (MEM_LAT - 1) @(negedge clk);
                mem_ready = 1'b1;
                mem_data  = mem_word(mem_addr);
                @(negedge clk);
                mem_ready = 1'b0;
                chk("R3 resp after fill", {30'd0, resp_valid, resp_hit}, 32'd2);
            end
        end
    end

    // One load, issued at the first point where the cache is ready.
    task automatic load(input logic [31:0] a, input bit noise);
        int waitc;
        int s;
        logic [27:0] t;
        int hw;
        int v;
        bit seen_req;
        waitc = 0;
        while (!req_ready && waitc < 100) begin
            @(negedge clk); waitc++;
        end
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        if (noise) begin
            req_valid = 1'b1; req_addr = a ^ 32'h100;
        end else begin
            req_valid = 1'b0;
        end
        waitc = 0; seen_req = 0;
        while (!resp_valid && waitc < 100) begin
            if (mem_req && !seen_req) begin
                seen_req = 1;
                chk("R3 mem_addr", mem_addr, {a[31:2], 2'b00});
            end
            @(negedge clk); waitc++;
        end
        req_valid = 1'b0;
        s = int'(a[3:2]); t = a[31:4]; hw = -1;
        for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
        if (hw >= 0) begin
            mu[s] = (hw == 0); exp_hits++;
            chk("R4 hit latency", waitc, 1);
        end else begin
            v = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(mu[s]));
            mv[s][v] = 1; mt[s][v] = t; mu[s] = (v == 0); exp_miss++;
        end
        last_hit = resp_hit;
        chk("R2 resp_hit", {31'd0, resp_hit}, {31'd0, hw >= 0});
        chk("R2 resp_data", resp_data, mem_word(a));
        chk("R10 hit_count", {16'd0, hit_count}, exp_hits);
        chk("R10 miss_count", {16'd0, miss_count}, exp_miss);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R6: 0x04, 0x24 fill both ways; 0x54 replaces 0x04.
        load(32'h04, 0); chk("R5 first miss", {31'd0, last_hit}, 32'd0);
        load(32'h24, 0); chk("R5 second way", {31'd0, last_hit}, 32'd0);
        load(32'h04, 0); chk("R5 both kept", {31'd0, last_hit}, 32'd1);
        load(32'h24, 0); chk("R6 mru hit", {31'd0, last_hit}, 32'd1);
        load(32'h54, 0); chk("R6 evict miss", {31'd0, last_hit}, 32'd0);
        load(32'h24, 0); chk("R6 kept 0x24", {31'd0, last_hit}, 32'd1);
        load(32'h04, 0); chk("R6 evicted 0x04", {31'd0, last_hit}, 32'd0);

        // R1: offset bits do not change the lookup.
        load(32'h27, 0); chk("R1 offset hit", {31'd0, last_hit}, 32'd1);
        load(32'h05, 0); chk("R1 offset hit 2", {31'd0, last_hit}, 32'd1);

        // R7: alternating loop from reset.
        do_reset();
        for (int i = 0; i < 5; i++) begin
            load(32'h4, 0);
            load(32'h24, 0);
        end
        chk("R7 misses", {16'd0, miss_count}, 32'd2);
        chk("R7 hits", {16'd0, hit_count}, 32'd8);

        // R8: a held request during a miss and during a hit is ignored.
        load(32'h1008, 1);
        load(32'h1008, 1);
        load(32'h1108, 0); chk("R8 alias not cached", {31'd0, last_hit}, 32'd0);

        // R9: reset drops cached lines.
        do_reset();
        load(32'h24, 0); chk("R9 cleared line misses", {31'd0, last_hit}, 32'd0);

        // Random loads over a small pool of tags.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = {24'd0, 4'($urandom_range(0, 5)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            if ($urandom_range(0, 9) == 0) a[31:28] = 4'hA;
            load(a, $urandom_range(0, 7) == 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule